// File: doc/BRIEF.md
# Hysteretic Lock Detector

This block decides whether a control loop has settled by watching a stream of signed error samples. Each sample marked valid is compared in magnitude against a threshold. Samples inside the tolerance raise a confidence counter and samples outside it lower the counter. The counter stops rising at a lock point. When it reaches that point, the lock flag is raised.

Out-of-tolerance samples wear the counter down only as far as a lower unlock point. When the counter lands exactly on that point, the counter snaps to zero and the flag drops. A run of bad samples therefore has to be long enough to drain the built-up confidence before lock is lost. After that, a full run of good samples is needed to regain lock.

Typical settings are a tight threshold with a lock point of 1000 and an unlock point of 990 for a frequency loop. A phase loop might use a threshold of 500 with points of 10000 and 9900. The threshold and both points are plain inputs, so one instance can serve either loop. An init input restarts the detector at any time.

Top module: `lock_hyst_det`

## Requirements
- R1: After reset the lock flag is 0 and the counter is 0, so `lock_pts` good samples are needed before lock.
- R2: A sample is in tolerance when |err_in| <= thr_in, with err_in two's complement and thr_in unsigned. The most negative err_in has magnitude 2^(EW-1).
- R3: An in-tolerance sample increments the counter only while it is below `lock_pts`; otherwise the counter holds.
- R4: The lock flag is set on the sample after which the counter equals `lock_pts`. With `lock_pts` = 0, any in-tolerance sample sets it.
- R5: An out-of-tolerance sample decrements the counter only while it is above `unlock_pts`.
- R6: When the counter equals `unlock_pts` after an out-of-tolerance sample, the counter is cleared to 0 and the lock flag is cleared.
- R7: An out-of-tolerance sample with the counter below `unlock_pts` leaves the counter and the flag unchanged.
- R8: A high `init` clears the counter and the lock flag, and takes priority over a sample in the same cycle.
- R9: While `smp_vld` and `init` are low, the counter and the flag do not change.
- R10: The flag is registered. It shows the effect of a sample from the clock edge at which `smp_vld` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| init | input | 1 | Synchronous restart of counter and flag |
| smp_vld | input | 1 | Error sample strobe |
| err_in | input | EW | Signed error sample |
| thr_in | input | EW | Unsigned tolerance threshold |
| lock_pts | input | CW | Counter value at which lock is declared |
| unlock_pts | input | CW | Counter value at which lock is dropped |
| locked | output | 1 | Lock flag |

## Verification
Every result of this block is due one clock edge after the stimulus. The sample and its settings are captured at a rising edge, and `locked` holds the outcome from just after that edge. The bench changes its inputs on the falling edge and waits for one rising edge. It then updates its own model with the same values and compares `locked` at the next falling edge, so no comparison is made while the register may be changing. The internal counter is not a port. Its value is checked through how many later good or bad samples it takes before the flag changes.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_UP    = 2'd1,
    ACT_DOWN  = 2'd2,
    ACT_CLEAR = 2'd3
  } cnt_act_e;
endpackage

// File: rtl/lockdet_tol_cmp.sv
module lockdet_tol_cmp #(
  parameter int EW = 16
) (
  input  logic [EW-1:0] err_in,
  input  logic [EW-1:0] thr_in,
  output logic          in_tol
);
  localparam int MW = EW + 1;

  // magnitude carries one extra bit so the most negative value fits
  function automatic logic [MW-1:0] err_mag(input logic [EW-1:0] e);
    logic [MW-1:0] ext;
    ext = {e[EW-1], e};
    return e[EW-1] ? (~ext + MW'(1)) : ext;
  endfunction

  always_comb in_tol = (err_mag(err_in) <= {1'b0, thr_in});
endmodule

// File: rtl/lockdet_step_sel.sv
module lockdet_step_sel
  import lockdet_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          init,
  input  logic          smp_vld,
  input  logic          in_tol,
  input  logic [CW-1:0] count_q,
  input  logic [CW-1:0] lock_pts,
  input  logic [CW-1:0] unlock_pts,
  output cnt_act_e      act,
  output logic          set_lock,
  output logic          hit_unlock
);
  function automatic logic [CW-1:0] rise_val(input logic [CW-1:0] c,
                                             input logic [CW-1:0] top);
    return (c < top) ? c + CW'(1) : c;
  endfunction

  function automatic logic [CW-1:0] fall_val(input logic [CW-1:0] c,
                                             input logic [CW-1:0] floor_v);
    return (c > floor_v) ? c - CW'(1) : c;
  endfunction

  logic [CW-1:0] up_v, dn_v;
  always_comb begin
    up_v = rise_val(count_q, lock_pts);
    dn_v = fall_val(count_q, unlock_pts);
  end

  always_comb begin
    act        = ACT_HOLD;
    set_lock   = 1'b0;
    hit_unlock = 1'b0;
    if (init) begin
      act = ACT_CLEAR;
    end else if (smp_vld) begin
      if (in_tol) begin
        if (up_v != count_q) act = ACT_UP;
        set_lock = (up_v == lock_pts);
      end else begin
        if (dn_v == unlock_pts) begin
          act        = ACT_CLEAR;
          hit_unlock = 1'b1;
        end else if (dn_v != count_q) begin
          act = ACT_DOWN;
        end
      end
    end
  end
endmodule

// File: rtl/lockdet_cnt_reg.sv
module lockdet_cnt_reg
  import lockdet_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  cnt_act_e      act,
  input  logic          set_lock,
  output logic [CW-1:0] count_q,
  output logic          locked_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q  <= '0;
      locked_q <= 1'b0;
    end else begin
      unique case (act)
        ACT_UP:    count_q <= count_q + CW'(1);
        ACT_DOWN:  count_q <= count_q - CW'(1);
        ACT_CLEAR: count_q <= '0;
        default:   count_q <= count_q;
      endcase
      if (act == ACT_CLEAR) locked_q <= 1'b0;
      else if (set_lock)    locked_q <= 1'b1;
    end
  end
endmodule

// File: rtl/lock_hyst_det.sv
module lock_hyst_det
  import lockdet_pkg::*;
#(
  parameter int EW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init,
  input  logic          smp_vld,
  input  logic [EW-1:0] err_in,
  input  logic [EW-1:0] thr_in,
  input  logic [CW-1:0] lock_pts,
  input  logic [CW-1:0] unlock_pts,
  output logic          locked
);
  logic          in_tol;
  cnt_act_e      act;
  logic          set_lock;
  logic          hit_unlock;
  logic [CW-1:0] count_q;

  lockdet_tol_cmp #(.EW(EW)) tol_i (
    .err_in (err_in),
    .thr_in (thr_in),
    .in_tol (in_tol)
  );

  lockdet_step_sel #(.CW(CW)) sel_i (
    .init       (init),
    .smp_vld    (smp_vld),
    .in_tol     (in_tol),
    .count_q    (count_q),
    .lock_pts   (lock_pts),
    .unlock_pts (unlock_pts),
    .act        (act),
    .set_lock   (set_lock),
    .hit_unlock (hit_unlock)
  );

  lockdet_cnt_reg #(.CW(CW)) reg_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .act      (act),
    .set_lock (set_lock),
    .count_q  (count_q),
    .locked_q (locked)
  );
endmodule

// File: rtl/lock_hyst_det_chk.sv
module lock_hyst_det_chk #(
  parameter int EW = 16,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          init,
  input logic          smp_vld,
  input logic [EW-1:0] err_in,
  input logic [EW-1:0] thr_in,
  input logic [CW-1:0] lock_pts,
  input logic [CW-1:0] unlock_pts,
  input logic          in_tol,
  input logic          hit_unlock,
  input logic [CW-1:0] count_q,
  input logic          locked
);
  // R2
  zero_err_in_tol_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_in == '0) |-> in_tol);

  // R2
  zero_thr_out_tol_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_in == '0 && err_in != '0) |-> !in_tol);

  // R3
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!init && smp_vld && in_tol && count_q >= lock_pts) |=> (count_q == $past(count_q)));

  // R5
  decay_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!init && smp_vld && !in_tol && count_q > unlock_pts + CW'(1) && unlock_pts != '1)
      |=> (count_q == $past(count_q) - CW'(1)));

  // R6
  unlock_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_unlock |=> (count_q == '0 && !locked));

  // R7
  below_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!init && smp_vld && !in_tol && count_q < unlock_pts) |=> ($stable(count_q) && $stable(locked)));

  // R8
  init_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (!locked && count_q == '0));

  // R9
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!init && !smp_vld) |=> ($stable(locked) && $stable(count_q)));

  // R4
  rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(smp_vld && in_tol && !init));

  // R6
  fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(init || (smp_vld && !in_tol)));
endmodule

bind lock_hyst_det lock_hyst_det_chk #(.EW(EW), .CW(CW)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .init       (init),
  .smp_vld    (smp_vld),
  .err_in     (err_in),
  .thr_in     (thr_in),
  .lock_pts   (lock_pts),
  .unlock_pts (unlock_pts),
  .in_tol     (in_tol),
  .hit_unlock (hit_unlock),
  .count_q    (count_q),
  .locked     (locked)
);

// File: tb/lock_hyst_det_tb.sv
module lock_hyst_det_tb_top;
  localparam int EW = 16;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          init = 1'b0;
  logic          smp_vld = 1'b0;
  logic [EW-1:0] err_in = '0;
  logic [EW-1:0] thr_in = '0;
  logic [CW-1:0] lock_pts = '0;
  logic [CW-1:0] unlock_pts = '0;
  logic          locked;

  int total = 0;
  int bad = 0;

  // behavioural reference
  int m_cnt = 0;
  bit m_lock = 0;

  always #10 clk = ~clk;

  lock_hyst_det #(.EW(EW), .CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .init(init), .smp_vld(smp_vld),
    .err_in(err_in), .thr_in(thr_in), .lock_pts(lock_pts),
    .unlock_pts(unlock_pts), .locked(locked)
  );

  task automatic check(input string req, input bit exp);
    total++;
    if (locked !== exp) begin
      bad++;
      $display("FAIL %s: locked=%b expected=%b (t=%0t)", req, locked, exp, $time);
    end
  endtask

  task automatic model_step(input bit i, input bit v, input int e, input int thr,
                            input int lp, input int up);
    int mag;
    mag = (e < 0) ? -e : e;
    if (i) begin
      m_cnt = 0;
      m_lock = 0;
    end else if (v) begin
      if (mag <= thr) begin
        if (m_cnt < lp) m_cnt = m_cnt + 1;
        if (m_cnt == lp) m_lock = 1;
      end else begin
        if (m_cnt > up) m_cnt = m_cnt - 1;
        if (m_cnt == up) begin
          m_cnt = 0;
          m_lock = 0;
        end
      end
    end
  endtask

  // one clock: drive at falling edge, compare at the next falling edge
  task automatic step(input string req, input bit i, input bit v, input int e);
    init    = i;
    smp_vld = v;
    err_in  = EW'(e);
    @(posedge clk);
    model_step(i, v, e, int'(thr_in), int'(lock_pts), int'(unlock_pts));
    @(negedge clk);
    check(req, m_lock);
  endtask

  task automatic cfg(input int thr, input int lp, input int up);
    thr_in     = EW'(thr);
    lock_pts   = CW'(lp);
    unlock_pts = CW'(up);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: run did not finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cfg(2, 5, 3);
    repeat (3) @(negedge clk);
    check("R1", 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 1'b0);

    // R1 R4 R10: five good samples needed, flag after fifth edge
    step("R1", 0, 1, 2);
    step("R1", 0, 1, -2);
    step("R1", 0, 1, 0);
    step("R1", 0, 1, 1);
    step("R4", 0, 1, -1);
    // R3: saturation, extra good samples do not raise the counter
    for (int k = 0; k < 4; k++) step("R3", 0, 1, 0);
    // R5: 5 -> 4 keeps lock, R6: 4 -> 3 clears
    step("R5", 0, 1, 3);
    step("R6", 0, 1, -3);
    // R7: counter 0 below floor, bad samples change nothing
    step("R7", 0, 1, 100);
    step("R7", 0, 1, -100);
    for (int k = 0; k < 4; k++) step("R6", 0, 1, 0);
    step("R6", 0, 1, 0);
    // R8: init during lock, then full run needed
    step("R8", 1, 1, 0);
    for (int k = 0; k < 5; k++) step("R8", 0, 1, 0);
    // R9: idle with bad error does nothing
    for (int k = 0; k < 3; k++) step("R9", 0, 0, 30000);
    step("R9", 0, 0, 0);
    // R7: counter 2 below floor 3 stays put
    step("R8", 1, 0, 0);
    step("R7", 0, 1, 0);
    step("R7", 0, 1, 0);
    step("R7", 0, 1, 9);
    step("R7", 0, 1, 0);
    step("R7", 0, 1, 0);
    step("R7", 0, 1, 0);
    // R2: most negative value has magnitude 32768
    step("R8", 1, 0, 0);
    cfg(32767, 1, 0);
    step("R2", 0, 1, -32768);
    step("R2", 0, 1, -32767);
    cfg(65535, 1, 0);
    step("R8", 1, 0, 0);
    step("R2", 0, 1, -32768);
    // R6 with floor 0: lock 2, two bad samples clear
    cfg(2, 2, 0);
    step("R8", 1, 0, 0);
    step("R4", 0, 1, 0);
    step("R4", 0, 1, 0);
    step("R5", 0, 1, 5);
    step("R6", 0, 1, 5);
    step("R6", 0, 1, 0);
    // R4 with lock point 0: single good sample locks
    cfg(2, 0, 0);
    step("R8", 1, 0, 0);
    step("R4", 0, 1, 1);
    // R8 priority over a sample in the same cycle
    step("R8", 1, 1, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule